// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits on the transmit path of an Ethernet MAC. It accepts one outgoing frame at a time on a byte-wide valid/ready stream. The beat that closes a frame also carries three 32-bit sideband words. The frame is held whole in an internal buffer, because the checksum may land anywhere in it. If the sideband asks for it, the block forms a 16-bit ones-complement checksum over the tail of the frame and overwrites two bytes with the result. It then streams the frame out on a second byte-wide valid/ready port.

A transmit control register gates the path. A clear enable bit silently discards frames. With both the jumbo and VLAN bits clear, frames just above the standard maximum length are discarded. Each frame sent produces a one-cycle completion pulse and adds its length to a 64-bit byte counter.

The controller is a four-state machine. RECV stores bytes and, on the closing beat, goes back to RECV if the frame is discarded. It goes to SEND if no checksum is requested, to FOLD if the checksum start lies at or past the end of the frame, and to SUM otherwise. SUM adds one byte per cycle and moves to FOLD after the last byte. FOLD folds one carry per cycle and moves to SEND once no carry remains. SEND emits one byte per accepted beat and returns to RECV after the final byte.

Top module: `tx_csum_inserter`

## Requirements
- R1: After reset, `ctrl_q` reads 0x5800_0000 (jumbo bit 30, enable bit 28 and VLAN bit 27 set), `byte_count` is 0, `out_valid` is low and `in_ready` is high.
- R2: A write on `ctrl_wr` stores `ctrl_wdata` in `ctrl_q`, except that a write with bit 31 set loads 0x5800_0000 instead.
- R3: A frame that completes while bit 28 of `ctrl_q` is clear is accepted and discarded: no output byte, no `tx_done` pulse, `byte_count` unchanged.
- R4: When bits 30 and 27 of `ctrl_q` are both clear, frames of 1519 to 1522 bytes are discarded as in R3. Frames of 1518 or 1523 bytes are sent, and a 1520-byte frame is sent when either bit is set.
- R5: When bit 0 of header word 0 is clear, the frame is sent byte for byte as received.
- R6: When bit 0 of header word 0 is set, the checksum is computed as follows. Bytes from the start offset (header word 1 bits 31:16) to the end are taken as big-endian 16-bit words; an odd trailing byte takes the high position, padded with zero. Bits 15:0 of header word 2 are added to the sum. Carries are folded back until none remains, and the result is complemented. Its high byte replaces the byte at the write offset (header word 1 bits 15:0) and its low byte the next one; a position at or past the frame end is not written. A start offset at or past the end gives a sum of the seed alone.
- R7: The header words are sampled only on the beat that carries `in_last`.
- R8: Output bytes appear in input order, `out_last` is high on the final byte only, `out_data`/`out_last` hold while `out_valid` is high and `out_ready` low, and `in_ready` is low whenever `out_valid` is high.
- R9: One clock after the final output byte is accepted, `tx_done` is high for exactly one cycle and `byte_count` has grown by the frame length.
- R10: Input bytes beyond `MAX_BYTES` in one frame are dropped, and the frame length counts as `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl_q | output | 32 | Control register contents |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the input frame |
| hdr0 | input | 32 | Sideband word 0 (bit 0: insert checksum) |
| hdr1 | input | 32 | Sideband word 1 (start offset 31:16, write offset 15:0) |
| hdr2 | input | 32 | Sideband word 2 (seed in 15:0) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the output frame |
| tx_done | output | 1 | One-cycle pulse per sent frame |
| byte_count | output | 64 | Total bytes sent since reset |

## Verification
A wrong fold or a mis-tracked byte parity in SUM shows only in the two inserted bytes, on the first output beat that reaches the write offset. The bench therefore compares whole frames against a checksum computed on its own, using odd lengths, heavy seeds and offsets at the frame edge. A wrong length register or a stuck state shows at once as a missing or extra `out_last`, a missing `tx_done` pulse or a byte counter that is off by the frame length. A gating error shows as output appearing, or failing to appear, within a few cycles of the closing input beat.

// File: rtl/tx_csum_pkg.sv
package tx_csum_pkg;
    typedef enum logic [1:0] {
        ST_RECV = 2'd0,
        ST_SUM  = 2'd1,
        ST_FOLD = 2'd2,
        ST_SEND = 2'd3
    } tx_state_t;

    localparam int CTL_VLAN_BIT  = 27;
    localparam int CTL_EN_BIT    = 28;
    localparam int CTL_JUMBO_BIT = 30;
    localparam int CTL_SRST_BIT  = 31;
    localparam logic [31:0] CTL_RST_VAL =
        (32'd1 << CTL_JUMBO_BIT) | (32'd1 << CTL_EN_BIT) | (32'd1 << CTL_VLAN_BIT);

    localparam int STD_MAX_LEN  = 1518;
    localparam int TAG_MAX_LEN  = 1522;
endpackage

// File: rtl/tx_frame_buf.sv
module tx_frame_buf #(
    parameter int DEPTH = 2048,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tx_len_gate.sv
module tx_len_gate #(
    parameter int LW = 12
) (
    input  logic [LW-1:0] len,
    input  logic          en_bit,
    input  logic          jumbo_bit,
    input  logic          vlan_bit,
    output logic          drop
);
    import tx_csum_pkg::*;

    logic tagged_size;

    always_comb begin
        tagged_size = (32'(len) > STD_MAX_LEN) && (32'(len) <= TAG_MAX_LEN);
        drop = !en_bit || (!jumbo_bit && !vlan_bit && tagged_size);
    end
endmodule

// File: rtl/tx_csum_acc.sv
module tx_csum_acc (
    input  logic        clk,
    input  logic        load,
    input  logic [15:0] load_val,
    input  logic        add_en,
    input  logic [7:0]  add_byte,
    input  logic        add_hi,
    input  logic        fold_en,
    output logic        has_carry,
    output logic [15:0] csum
);
    logic [31:0] acc;

    always_ff @(posedge clk) begin
        if (load)
            acc <= {16'd0, load_val};
        else if (add_en)
            acc <= acc + (add_hi ? {16'd0, add_byte, 8'd0} : {24'd0, add_byte});
        else if (fold_en)
            acc <= {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
    end

    assign has_carry = (acc[31:16] != 16'd0);
    assign csum      = ~acc[15:0];
endmodule

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter #(
    parameter int MAX_BYTES = 2048,
    localparam int LW = $clog2(MAX_BYTES + 1),
    localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_wdata,
    output logic [31:0] ctrl_q,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic [31:0] hdr0,
    input  logic [31:0] hdr1,
    input  logic [31:0] hdr2,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        tx_done,
    output logic [63:0] byte_count
);
    import tx_csum_pkg::*;

    tx_state_t state, state_nx;

    logic [LW-1:0] wr_cnt, len_q, idx, len_new;
    logic          csum_en_q, hi_q;
    logic [15:0]   wrof_q;
    logic          buf_room, accept, frame_end, drop;
    logic          acc_load, acc_add, acc_fold, acc_carry;
    logic [15:0]   csum;
    logic [7:0]    rd_data;
    logic          start_past_end;
    logic          unused_hdr;

    assign unused_hdr = ^{hdr0[31:1], hdr2[31:16]};

    assign buf_room  = (wr_cnt < LW'(MAX_BYTES));
    assign accept    = (state == ST_RECV) && in_valid;
    assign frame_end = accept && in_last;
    assign len_new   = buf_room ? wr_cnt + 1'b1 : wr_cnt;
    assign start_past_end = (17'(hdr1[31:16]) >= 17'(len_new));

    tx_frame_buf #(.DEPTH(MAX_BYTES)) u_buf (
        .clk     (clk),
        .wr_en   (accept && buf_room),
        .wr_addr (wr_cnt[AW-1:0]),
        .wr_data (in_data),
        .rd_addr (idx[AW-1:0]),
        .rd_data (rd_data)
    );

    tx_len_gate #(.LW(LW)) u_gate (
        .len       (len_new),
        .en_bit    (ctrl_q[CTL_EN_BIT]),
        .jumbo_bit (ctrl_q[CTL_JUMBO_BIT]),
        .vlan_bit  (ctrl_q[CTL_VLAN_BIT]),
        .drop      (drop)
    );

    tx_csum_acc u_acc (
        .clk       (clk),
        .load      (acc_load),
        .load_val  (hdr2[15:0]),
        .add_en    (acc_add),
        .add_byte  (rd_data),
        .add_hi    (hi_q),
        .fold_en   (acc_fold),
        .has_carry (acc_carry),
        .csum      (csum)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RECV;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = rd_data;
        acc_load  = 1'b0;
        acc_add   = 1'b0;
        acc_fold  = 1'b0;
        unique case (state)
            ST_RECV: begin
                in_ready = 1'b1;
                acc_load = frame_end;
                if (frame_end && !drop) begin
                    if (!hdr0[0])            state_nx = ST_SEND;
                    else if (start_past_end) state_nx = ST_FOLD;
                    else                     state_nx = ST_SUM;
                end
            end
            ST_SUM: begin
                acc_add = 1'b1;
                if (idx + 1'b1 == len_q) state_nx = ST_FOLD;
            end
            ST_FOLD: begin
                acc_fold = acc_carry;
                if (!acc_carry) state_nx = ST_SEND;
            end
            ST_SEND: begin
                out_valid = 1'b1;
                out_last  = (idx + 1'b1 == len_q);
                if (csum_en_q && 17'(wrof_q) == 17'(idx))
                    out_data = csum[15:8];
                else if (csum_en_q && 17'(wrof_q) + 17'd1 == 17'(idx))
                    out_data = csum[7:0];
                if (out_ready && out_last) state_nx = ST_RECV;
            end
            default: state_nx = ST_RECV;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= CTL_RST_VAL;
            wr_cnt     <= '0;
            len_q      <= '0;
            idx        <= '0;
            csum_en_q  <= 1'b0;
            hi_q       <= 1'b1;
            wrof_q     <= '0;
            tx_done    <= 1'b0;
            byte_count <= '0;
        end else begin
            tx_done <= 1'b0;
            if (ctrl_wr)
                ctrl_q <= ctrl_wdata[CTL_SRST_BIT] ? CTL_RST_VAL : ctrl_wdata;
            unique case (state)
                ST_RECV: if (accept) begin
                    wr_cnt <= len_new;
                    if (in_last) begin
                        wr_cnt    <= '0;
                        len_q     <= len_new;
                        csum_en_q <= hdr0[0];
                        wrof_q    <= hdr1[15:0];
                        hi_q      <= 1'b1;
                        idx       <= (hdr0[0] && !start_past_end) ? LW'(hdr1[31:16]) : '0;
                    end
                end
                ST_SUM: begin
                    hi_q <= ~hi_q;
                    idx  <= (idx + 1'b1 == len_q) ? '0 : idx + 1'b1;
                end
                ST_FOLD: ;
                ST_SEND: if (out_ready) begin
                    idx <= idx + 1'b1;
                    if (out_last) begin
                        idx        <= '0;
                        tx_done    <= 1'b1;
                        byte_count <= byte_count + 64'(len_q);
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: no input accepted while a frame is on the output
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R8: output held under back-pressure
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
    // R9: completion comes with a counter increase
    a_r9_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (byte_count > $past(byte_count)));
    // R2: soft reset bit restores the control defaults
    a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[CTL_SRST_BIT]) |=> (ctrl_q == CTL_RST_VAL));
    // R3: disabled path produces no output after a frame closes
    a_r3_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !ctrl_q[CTL_EN_BIT]) |=> !out_valid);
    // R10: stored byte count never exceeds the buffer
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt <= LW'(MAX_BYTES)) && (len_q <= LW'(MAX_BYTES)));
endmodule

// File: tb/tx_csum_inserter_tb.sv
module tx_csum_inserter_tb;
    localparam int MAXB = 2048;
    localparam int BUFN = 2100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_q;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [31:0] hdr0 = '0, hdr1 = '0, hdr2 = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_last;
    logic        tx_done;
    logic [63:0] byte_count;

    always #2.5 clk = ~clk;

    tx_csum_inserter #(.MAX_BYTES(MAXB)) u_dut (.*);

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    logic [7:0] frm   [BUFN];
    logic [7:0] exp_b [BUFN];
    logic [7:0] rx_b  [BUFN];
    int rx_cnt = 0, last_cnt = 0, last_pos = -1, done_cnt = 0, overlap_err = 0;
    bit stall_mode = 1'b0;
    int rdy_ctr = 0;
    longint unsigned exp_bc = 0;

    // len16 start16 wr16 seed16 en1 stall1 pat8
    localparam int NV = 7;
    localparam logic [73:0] VECS [NV] = '{
        {16'd60, 16'd14, 16'd40, 16'h0000, 1'b1, 1'b0, 8'd3},
        {16'd61, 16'd20, 16'd30, 16'hABCD, 1'b1, 1'b1, 8'd7},
        {16'd64, 16'd0,  16'd0,  16'hFFFF, 1'b1, 1'b0, 8'd255},
        {16'd40, 16'd10, 16'd39, 16'h1234, 1'b1, 1'b1, 8'd11},
        {16'd30, 16'd35, 16'd5,  16'h00FF, 1'b1, 1'b0, 8'd5},
        {16'd50, 16'd0,  16'd0,  16'h0000, 1'b0, 1'b1, 8'd9},
        {16'd1,  16'd0,  16'd0,  16'h8000, 1'b1, 1'b0, 8'd1}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // output monitor
    always @(negedge clk) begin
        rdy_ctr++;
        out_ready = !stall_mode || (rdy_ctr % 3 != 0);
        #1;
        if (out_valid && out_ready) begin
            if (rx_cnt < BUFN) rx_b[rx_cnt] = out_data;
            if (out_last) begin last_cnt++; last_pos = rx_cnt; end
            rx_cnt++;
        end
        if (out_valid && in_ready) overlap_err++;
        if (tx_done) done_cnt++;
    end

    function automatic logic [15:0] ref_csum(input int len, input int start, input logic [15:0] seed);
        longint unsigned s = 0;
        for (int i = start; i < len; i++)
            s += ((i - start) % 2 == 0) ? {48'd0, frm[i], 8'd0} : {56'd0, frm[i]};
        s += seed;
        while (s >> 16 != 0) s = (s & 64'hFFFF) + (s >> 16);
        return ~s[15:0];
    endfunction

    task automatic write_ctrl(input logic [31:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic drive(input int len, input logic [31:0] h0, input logic [31:0] h1, input logic [31:0] h2);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = frm[i]; in_last = (i == len - 1);
            // R7: header words are wrong except on the closing beat
            hdr0 = in_last ? h0 : ~h0;
            hdr1 = in_last ? h1 : ~h1;
            hdr2 = in_last ? h2 : ~h2;
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic run_frame(input int len, input int start, input int wr, input int seed,
                             input bit en, input bit stall, input int pat, input bit sent,
                             input string req);
        int elen, d0, mism;
        logic [15:0] cs;
        longint unsigned bc0;
        for (int i = 0; i < len; i++) frm[i] = 8'((i * pat + (pat ^ 8'h5A)) & 8'hFF);
        elen = (len > MAXB) ? MAXB : len;
        for (int i = 0; i < elen; i++) exp_b[i] = frm[i];
        if (en) begin
            cs = ref_csum(elen, start, 16'(seed));
            if (wr < elen)     exp_b[wr]     = cs[15:8];
            if (wr + 1 < elen) exp_b[wr + 1] = cs[7:0];
        end
        stall_mode = stall;
        rx_cnt = 0; last_cnt = 0; last_pos = -1;
        d0 = done_cnt; bc0 = byte_count;
        drive(len, {31'd0, en}, {16'(start), 16'(wr)}, {16'hDEAD, 16'(seed)});
        if (sent) begin
            for (int t = 0; t < 6000 && done_cnt == d0; t++) @(negedge clk);
            repeat (2) @(negedge clk);
            exp_bc += 64'(elen);
            mism = 0;
            for (int i = 0; i < elen; i++) if (rx_b[i] !== exp_b[i]) mism++;
            chk(rx_cnt == elen, {req, " R8 length"}, rx_cnt, elen);
            chk(mism == 0, {req, " R6 R5 bytes"}, mism, 0);
            chk(last_cnt == 1 && last_pos == elen - 1, {req, " R8 last"}, last_pos, elen - 1);
            chk(done_cnt == d0 + 1, {req, " R9 done"}, done_cnt - d0, 1);
            chk(byte_count == exp_bc, {req, " R9 count"}, byte_count, exp_bc);
        end else begin
            repeat (30) @(negedge clk);
            chk(rx_cnt == 0 && done_cnt == d0, {req, " dropped"}, rx_cnt, 0);
            chk(byte_count == bc0, {req, " count held"}, byte_count, bc0);
        end
        stall_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_q == 32'h5800_0000, "R1 ctrl", ctrl_q, 32'h5800_0000);
        chk(byte_count == 0, "R1 count", byte_count, 0);
        chk(!out_valid, "R1 out_valid", out_valid, 0);
        chk(in_ready, "R1 in_ready", in_ready, 1);

        // table of vectors: R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++)
            run_frame(int'(VECS[v][73:58]), int'(VECS[v][57:42]), int'(VECS[v][41:26]),
                      int'(VECS[v][25:10]), VECS[v][9], VECS[v][8], int'(VECS[v][7:0]),
                      1'b1, $sformatf("vec%0d", v));

        // R2 plain store
        write_ctrl(32'h1000_0000);
        @(negedge clk);
        chk(ctrl_q == 32'h1000_0000, "R2 store", ctrl_q, 32'h1000_0000);
        // R4 length gating with jumbo and VLAN clear
        run_frame(1519, 0, 0, 0, 1'b0, 1'b0, 13, 1'b0, "R4 1519");
        run_frame(1522, 0, 0, 0, 1'b0, 1'b0, 17, 1'b0, "R4 1522");
        run_frame(1518, 100, 200, 16'h4321, 1'b1, 1'b0, 19, 1'b1, "R4 1518");
        run_frame(1523, 0, 0, 0, 1'b0, 1'b0, 23, 1'b1, "R4 1523");
        write_ctrl(32'h1800_0000);
        run_frame(1520, 0, 0, 0, 1'b0, 1'b0, 29, 1'b1, "R4 1520 vlan");
        // R3 transmit disabled
        write_ctrl(32'h4800_0000);
        run_frame(60, 14, 20, 0, 1'b1, 1'b0, 31, 1'b0, "R3 disabled");
        // R2 soft reset bit
        write_ctrl(32'h8000_0001);
        @(negedge clk);
        chk(ctrl_q == 32'h5800_0000, "R2 soft reset", ctrl_q, 32'h5800_0000);
        // R10 oversize frame capped at MAX_BYTES
        run_frame(MAXB + 2, 0, 0, 0, 1'b0, 1'b0, 37, 1'b1, "R10 oversize");
        // R8 no input accepted while sending
        chk(overlap_err == 0, "R8 in_ready during send", overlap_err, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule